// File: doc/BRIEF.md
# Prescaled Modulo Counter with Handshake-Cleared Overflow Flag

This block is a free-running up-counter that advances once per prescaled tick and returns to zero after the tick on which it holds a programmable modulo value. A divider in front of it is chosen from a power-of-two set. Software controls it through one 8-bit status/control register on a small register bus. The register holds an overflow flag, an interrupt enable, a halt bit, a write-only restart bit and the divider select. The modulo value is a plain input port, and the live count is brought out on a port.

The overflow flag is kept by a three-state machine. `FLG_CLEAR` means the flag is 0. `FLG_PENDING` means the flag is 1 but has not yet been read. `FLG_ARMED` means the flag is 1 and has been read as 1. The transitions are as follows:
- `FLG_CLEAR`→`FLG_PENDING` on an overflow.
- `FLG_PENDING`→`FLG_ARMED` on a status read.
- `FLG_PENDING`→`FLG_PENDING` on an overflow.
- `FLG_ARMED`→`FLG_PENDING` on an overflow. An overflow always wins over a read or a write in the same cycle.
- `FLG_ARMED`→`FLG_CLEAR` on a status write with bit 7 at 0.

A second machine holds the run state. `RUN_HALTED` is the reset state. `RUN_ACTIVE` is entered by a status write with bit 5 at 0. A status write with bit 5 at 1 returns it to `RUN_HALTED`.

Top module: `tmr_modulo_top`

## Requirements
- R1: After reset the status register reads 0x20, the count is 0 and the interrupt request is low.
- R2: The status register sits at address 0 and reads as {flag, irq enable, halt, 0, 0, divider select[2:0]} from bit 7 down to bit 0. Bit 4 and bit 3 always read 0. Any other address reads 0x00, and writes to other addresses change nothing.
- R3: Divider select k in the range 0 to 6 makes the counter advance once every 2^k clock cycles. Select 7 behaves as select 6.
- R4: While running, the count rises by one on each tick. On a tick where the count equals the modulo input, the count becomes 0 instead.
- R5: The flag becomes 1 on the clock edge of the wrapping tick described in R4.
- R6: A status read that sees the flag at 1 arms a clear. A later status write with bit 7 at 0 then clears the flag. A write with bit 7 at 0 that has no arming read before it leaves the flag set.
- R7: An overflow that occurs after the arming read and before the write cancels the arming, so the write of 0 leaves the flag set.
- R8: A status write with bit 7 at 1 never changes the flag, and an arming read stays valid after such a write.
- R9: The interrupt request is high exactly while the flag and the interrupt enable (bit 6) are both 1.
- R10: While the halt bit (bit 5) is 1 the count and the divider hold their values. The halt bit takes effect from the edge that writes it, and reset sets it.
- R11: A status write with bit 4 at 1 sets the count and the divider phase to 0, after which counting restarts from 0x0000. Bit 4 reads as 0.
- R12: A single write with both bit 5 and bit 4 at 1 leaves the count held at 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| modulo | input | CNT_W | Value the counter wraps at |
| count | output | CNT_W | Current counter value |
| irq | output | 1 | Overflow interrupt request |

## Verification
The flag properties assume that a read strobe and a write strobe never arrive in the same cycle. They also assume that the modulo input stays constant while the counter runs, so that a wrap is a well-defined event. The bench issues each access as a one-cycle strobe on the falling edge, and only ever does one access at a time. It changes the modulo value only while the counter is halted or just before a restart write. The overflow-between test chooses its read and write edges from the known wrap phase. This places an overflow strictly between the two accesses and never on the write edge itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        FLG_CLEAR   = 2'd0,
        FLG_PENDING = 2'd1,
        FLG_ARMED   = 2'd2
    } flg_state_e;

    typedef enum logic {
        RUN_HALTED = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_e;

    localparam int BIT_FLAG = 7;
    localparam int BIT_IEN  = 6;
    localparam int BIT_HALT = 5;
    localparam int BIT_RST  = 4;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PS_W   = 3,
    parameter int PS_MAX = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int PRE_W = PS_MAX;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    int unsigned      sel_cap;

    always_comb begin
        sel_cap = (int'(sel) > PS_MAX) ? PS_MAX : int'(sel);
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < sel_cap);
        end
        tick = ((pre & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (clr) begin
            pre <= '0;
        end else if (en) begin
            pre <= pre + PRE_W'(1);
        end
    end

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre == '0)); // R11
    AST_PRE_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> (pre == $past(pre))); // R10
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stat_wr,
    input  logic            wr_ien,
    input  logic            wr_halt,
    input  logic            wr_rst,
    input  logic [PS_W-1:0] wr_ps,
    output logic            halted,
    output logic            ien,
    output logic [PS_W-1:0] ps,
    output logic            clr
);
    run_state_e run_q, run_d;

    always_comb begin
        run_d = run_q;
        unique case (run_q)
            RUN_HALTED: if (stat_wr && !wr_halt) run_d = RUN_ACTIVE;
            RUN_ACTIVE: if (stat_wr &&  wr_halt) run_d = RUN_HALTED;
            default:    run_d = RUN_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_HALTED;
            ien   <= 1'b0;
            ps    <= '0;
        end else begin
            run_q <= run_d;
            if (stat_wr) begin
                ien <= wr_ien;
                ps  <= wr_ps;
            end
        end
    end

    always_comb begin
        halted = (run_q == RUN_HALTED);
        clr    = stat_wr && wr_rst;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic at_mod;

    always_comb begin
        at_mod = (count == modulo);
        ovf    = run && tick && !clr && at_mod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (run && tick) begin
            count <= at_mod ? '0 : count + CNT_W'(1);
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == '0)); // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> (count == $past(count))); // R10
    AST_TRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0)); // R11
endmodule

// File: rtl/tmr_flag_fsm.sv
module tmr_flag_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic wr_flag,
    output logic flag
);
    flg_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_CLEAR: begin
                if (ovf) st_d = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (ovf)          st_d = FLG_PENDING;
                else if (stat_rd) st_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (ovf)                      st_d = FLG_PENDING;
                else if (stat_wr && !wr_flag) st_d = FLG_CLEAR;
            end
            default: st_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_d;
    end

    always_comb flag = (st_q != FLG_CLEAR);

    AST_OVF_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag); // R5
    AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLG_PENDING) |=> flag); // R6
    AST_OVF_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLG_ARMED && ovf) |=> (st_q == FLG_PENDING)); // R7
    AST_WRITE1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wr_flag && flag) |=> flag); // R8
endmodule

// File: rtl/tmr_modulo_top.sv
module tmr_modulo_top
    import tmr_pkg::*;
#(
    parameter int          CNT_W       = 16,
    parameter int          ADDR_W      = 2,
    parameter logic [1:0]  STATUS_ADDR = 2'd0,
    parameter int          PS_W        = 3,
    parameter int          PS_MAX      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [CNT_W-1:0]  modulo,
    output logic [CNT_W-1:0]  count,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(STATUS_ADDR);

    logic            sel, stat_rd, stat_wr;
    logic            halted, ien, clr, tick, ovf, flag, run;
    logic [PS_W-1:0] ps;
    logic            wdata_unused;

    always_comb begin
        sel          = (reg_addr == SEL_ADDR);
        stat_rd      = reg_rd && sel;
        stat_wr      = reg_wr && sel;
        run          = !halted;
        wdata_unused = reg_wdata[3];
    end

    tmr_ctrl #(.PS_W(PS_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (stat_wr),
        .wr_ien  (reg_wdata[BIT_IEN]),
        .wr_halt (reg_wdata[BIT_HALT]),
        .wr_rst  (reg_wdata[BIT_RST]),
        .wr_ps   (reg_wdata[PS_W-1:0]),
        .halted  (halted),
        .ien     (ien),
        .ps      (ps),
        .clr     (clr)
    );

    tmr_prescaler #(.PS_W(PS_W), .PS_MAX(PS_MAX)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .clr   (clr),
        .sel   (ps),
        .tick  (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .clr    (clr),
        .modulo (modulo),
        .count  (count),
        .ovf    (ovf)
    );

    tmr_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf     (ovf),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wr_flag (reg_wdata[BIT_FLAG]),
        .flag    (flag)
    );

    always_comb begin
        irq       = flag && ien;
        reg_rdata = '0;
        if (sel) begin
            reg_rdata[BIT_FLAG]   = flag;
            reg_rdata[BIT_IEN]    = ien;
            reg_rdata[BIT_HALT]   = halted;
            reg_rdata[PS_W-1:0]   = ps;
        end
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !reg_wdata[BIT_IEN]) |=> !irq); // R9
endmodule

// File: tb/tmr_modulo_top_tb.sv
module tmr_modulo_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] modulo = 16'd5;
    logic [15:0] count;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tmr_modulo_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .modulo(modulo), .count(count), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: expected count for each cycle after a restart write
    task automatic run_expect(input int sel, input int m, input int n, input string tag);
        int div;
        div = (sel > 6) ? 6 : sel;
        reg_write(2'd0, 8'h10 | 8'(sel));
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.val = 16'((i >> div) % (m + 1));
            e.tag = tag;
            exp_q.push_back(e);
        end
        wait (exp_q.size() == 0);
    endtask

    // Monitor: compares the live count against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, 32'(count), 32'(e.val));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 status", 32'(reg_rdata), 32'h20);
        chk("R1 count", 32'(count), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 halted after reset", 32'(count), 32'h0);

        // R2 other address reads zero and writes are ignored
        reg_read(2'd1, rd);
        chk("R2 other address read", 32'(rd), 32'h0);
        reg_write(2'd1, 8'h00);
        idle(4);
        chk("R2 other address write ignored", 32'(count), 32'h0);

        // R3/R4/R11: every divider select, restart clears divider phase
        modulo = 16'd5;
        for (int s = 0; s < 8; s++) begin
            int d;
            d = (s > 6) ? 6 : s;
            run_expect(s, 5, (1 << d) * 12 + 3, $sformatf("R3 divider sel %0d", s));
        end
        modulo = 16'd2;
        run_expect(0, 2, 10, "R4 wrap modulo 2");

        // R6/R8/R9 handshake while halted (flag already set)
        reg_write(2'd0, 8'h60);
        chk("R6 unarmed write0 keeps flag", 32'(irq), 32'h1);
        reg_read(2'd0, rd);
        chk("R2 layout read", 32'(rd), 32'hE0);
        reg_write(2'd0, 8'hE0);
        chk("R8 write1 keeps flag", 32'(irq), 32'h1);
        reg_write(2'd0, 8'h60);
        chk("R6 armed write0 clears", 32'(irq), 32'h0);
        reg_read(2'd0, rd);
        chk("R6 flag reads 0", 32'(rd), 32'h60);

        // R5 flag timing, R7 overflow between read and write
        modulo = 16'd3;
        reg_write(2'd0, 8'h50);
        idle(3);
        chk("R5 no flag before wrap", 32'(irq), 32'h0);
        idle(1);
        chk("R5 flag on wrap tick", 32'(irq), 32'h1);
        reg_read(2'd0, rd);
        idle(3);
        reg_write(2'd0, 8'h60);
        chk("R7 overflow voids clear", 32'(irq), 32'h1);
        reg_read(2'd0, rd);
        reg_write(2'd0, 8'h60);
        chk("R6 clear after re-read", 32'(irq), 32'h0);

        // R9 flag set but enable off
        reg_write(2'd0, 8'h50);
        idle(6);
        reg_write(2'd0, 8'h20);
        chk("R9 irq low with enable off", 32'(irq), 32'h0);
        reg_read(2'd0, rd);
        chk("R9 flag still visible", 32'(rd), 32'hA0);

        // R12 halt and restart together
        modulo = 16'd100;
        reg_write(2'd0, 8'h00);
        idle(3);
        reg_write(2'd0, 8'h30);
        chk("R12 count zero", 32'(count), 32'h0);
        idle(10);
        chk("R12 count held at zero", 32'(count), 32'h0);
        reg_read(2'd0, rd);
        chk("R11 restart bit reads 0", 32'(rd & 8'h7F), 32'h20);

        // R10 halt holds the count
        reg_write(2'd0, 8'h00);
        idle(5);
        chk("R10 running count", 32'(count), 32'd5);
        reg_write(2'd0, 8'h20);
        chk("R10 halted at write edge", 32'(count), 32'd7);
        idle(10);
        chk("R10 count held", 32'(count), 32'd7);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule